// File: doc/BRIEF.md
# Paged Memory-Map Chip-Select Decoder

This block turns the address and strobes of an 8-bit processor into chip selects and output enables for eight code-memory blocks, one data-RAM window and one memory-mapped I/O window. A 4-bit page register is added to the top of the 16-bit processor address, so the 64K-byte space reaches sixteen times as much code memory. Each code block occupies 16K bytes. The 16K slot it lives in is configurable, and so is the page it answers in, or it can be set to answer in every page. Blocks can be spread over the map or lined up from address 0. The RAM window (2K bytes) and the I/O window (256 bytes) answer in every page and can sit anywhere, including in the middle of code.

The placement fields, the page-register address and the space mode are sampled from configuration pins on every clock edge while reset is held, and are frozen once reset is released. In combined-space mode, either the program-store strobe or the read strobe may enable any target, and the address alone picks the winner. In separate-space mode, the program-store strobe competes only among code blocks, and the read strobe only among the page register, the I/O window and RAM. A write strobe to the page-register address loads the page register. A read at that address returns the page on the read-data pins.

All decode is combinational from the address, the strobes and the stored page. There is no data stream at the block's edge. Every pin is a plain control or status level, so no valid/ready handshake and no back-pressure apply.

Top module: `pgmap_decoder`

## Requirements
- R1: After reset the page register holds 0. With no strobe low, every chip select and output enable is high (inactive) and `rdata_vld` is 0.
- R2: On a clock edge where `wr_n` is low and `addr` equals the configured page-register address, the page register loads `wdata[3:0]`. At any other edge it keeps its value. A read-enabled access to that address drives `rdata_vld` high and `rdata` = {4'b0, page} in the same cycle. Otherwise `rdata` is 0.
- R3: Code block i matches when `addr[15:14]` equals its 2-bit slot field and either its any-page flag is set or the page register equals its 4-bit page field.
- R4: The RAM window matches when `addr[15:11]` equals the 5-bit RAM base. The I/O window matches when `addr[15:8]` equals the 8-bit I/O base. Neither depends on the page.
- R5: A single winner is chosen with fixed priority: page-register address, then I/O, then RAM, then code block 0 up to 7. At most one chip select is low, and the page-register address asserts no chip select.
- R6: In combined mode (`cfg_combined` = 1), a low `psen_n` or a low `rd_n` enables both code and data targets, and the winner's output enable goes low with its chip select.
- R7: In separate mode, a low `psen_n` alone can select only a code block. A low `rd_n` alone can select only the page register, the I/O window or RAM.
- R8: A low `wr_n` with no read-type strobe may select I/O or RAM with its output enable held high. It never selects a code block and never raises `rdata_vld`.
- R9: A strobe whose eligible regions all miss leaves every select inactive.
- R10: Configuration pins are captured only while `rst_n` is low. Changes after release have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_code_base | input | 16 | 2-bit 16K slot per code block, block i at bits [2i+1:2i] |
| cfg_code_page | input | 32 | 4-bit page per code block, block i at bits [4i+3:4i] |
| cfg_code_anypage | input | 8 | Per-block flag: answer in every page |
| cfg_ram_base | input | 5 | RAM window base, compared with addr[15:11] |
| cfg_io_base | input | 8 | I/O window base, compared with addr[15:8] |
| cfg_page_addr | input | 16 | Address of the page register |
| cfg_combined | input | 1 | 1 = combined code/data space, 0 = separate |
| addr | input | 16 | Processor address |
| psen_n | input | 1 | Program-store strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| wdata | input | 8 | Write data for the page register |
| rdata | output | 8 | Page register read-back, 0 when not selected |
| rdata_vld | output | 1 | High while the page register is being read |
| code_cs_n | output | 8 | Code block chip selects, active low |
| code_oe_n | output | 8 | Code block output enables, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| io_cs_n | output | 1 | I/O window chip select, active low |
| io_oe_n | output | 1 | I/O window output enable, active low |

## Verification
Selects, enables and read-back data are combinational. They are due in the same cycle as the address and strobes that cause them. A page written at one rising edge is first visible in the cycle after that edge. The bench drives each access at a falling edge and compares all outputs 3 ns later, before the next rising edge, against a behavioural model. It advances the model's page only after the edge that performs the write. This keeps both the same-cycle results and the one-edge page delay in step. The sweep walks all 16 pages and all 256 address slices under five strobe patterns in each space mode.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 4;
  localparam int DATA_W = 8;
  localparam int N_CODE = 8;
  localparam int CODE_W = 14;
  localparam int RAM_W  = 11;
  localparam int IO_W   = 8;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PREG,
    TGT_IO,
    TGT_RAM,
    TGT_CODE
  } tgt_e;
endpackage

// File: rtl/pgmap_cfg_regs.sv
module pgmap_cfg_regs #(
  parameter int AW  = 16,
  parameter int PW  = 4,
  parameter int NC  = 8,
  parameter int CBW = 2,
  parameter int RBW = 5,
  parameter int IBW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NC*CBW-1:0] code_base_i,
  input  logic [NC*PW-1:0]  code_page_i,
  input  logic [NC-1:0]     code_anypage_i,
  input  logic [RBW-1:0]    ram_base_i,
  input  logic [IBW-1:0]    io_base_i,
  input  logic [AW-1:0]     page_addr_i,
  input  logic              combined_i,
  output logic [NC*CBW-1:0] code_base_q,
  output logic [NC*PW-1:0]  code_page_q,
  output logic [NC-1:0]     code_anypage_q,
  output logic [RBW-1:0]    ram_base_q,
  output logic [IBW-1:0]    io_base_q,
  output logic [AW-1:0]     page_addr_q,
  output logic              combined_q
);
  // Capture while reset is held; hold afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_base_q    <= code_base_i;
      code_page_q    <= code_page_i;
      code_anypage_q <= code_anypage_i;
      ram_base_q     <= ram_base_i;
      io_base_q      <= io_base_i;
      page_addr_q    <= page_addr_i;
      combined_q     <= combined_i;
    end
  end
endmodule

// File: rtl/pgmap_page_reg.sv
module pgmap_page_reg #(
  parameter int AW = 16,
  parameter int PW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] page_addr,
  output logic [PW-1:0] page_q
);
  logic wr_hit;
  assign wr_hit = !wr_n && (addr == page_addr);

  always_ff @(posedge clk) begin
    if (!rst_n)      page_q <= '0;
    else if (wr_hit) page_q <= wdata[PW-1:0];
  end
endmodule

// File: rtl/pgmap_region_match.sv
module pgmap_region_match #(
  parameter int AW = 16,
  parameter int PW = 4,
  parameter int NC = 8,
  parameter int CW = 14,
  parameter int RW = 11,
  parameter int IW = 8
) (
  input  logic [AW-1:0]         addr,
  input  logic [PW-1:0]         page,
  input  logic [NC*(AW-CW)-1:0] code_base,
  input  logic [NC*PW-1:0]      code_page,
  input  logic [NC-1:0]         code_anypage,
  input  logic [AW-RW-1:0]      ram_base,
  input  logic [AW-IW-1:0]      io_base,
  input  logic [AW-1:0]         page_addr,
  output logic [NC-1:0]         code_hit,
  output logic                  ram_hit,
  output logic                  io_hit,
  output logic                  preg_hit
);
  localparam int CBW = AW - CW;

  for (genvar g = 0; g < NC; g++) begin : g_code
    logic slot_ok;
    logic page_ok;
    assign slot_ok     = addr[AW-1:CW] == code_base[g*CBW +: CBW];
    assign page_ok     = code_anypage[g] || (page == code_page[g*PW +: PW]);
    assign code_hit[g] = slot_ok && page_ok;
  end

  assign ram_hit  = addr[AW-1:RW] == ram_base;
  assign io_hit   = addr[AW-1:IW] == io_base;
  assign preg_hit = addr == page_addr;
endmodule

// File: rtl/pgmap_arbiter.sv
module pgmap_arbiter
  import pgmap_pkg::*;
#(
  parameter int NC = 8
) (
  input  logic [NC-1:0] code_hit,
  input  logic          ram_hit,
  input  logic          io_hit,
  input  logic          preg_hit,
  input  logic          psen_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          combined,
  output logic [NC-1:0] code_cs,
  output logic [NC-1:0] code_oe,
  output logic          ram_cs,
  output logic          ram_oe,
  output logic          io_cs,
  output logic          io_oe,
  output logic          preg_rd
);
  localparam int IDXW = (NC > 1) ? $clog2(NC) : 1;

  logic            code_en;
  logic            data_rd;
  logic            data_en;
  logic [IDXW-1:0] code_idx;
  tgt_e            tgt;

  // Strobe routing per address-space mode.
  always_comb begin
    code_en = combined ? (!psen_n || !rd_n) : !psen_n;
    data_rd = combined ? (!psen_n || !rd_n) : !rd_n;
    data_en = data_rd || !wr_n;
  end

  // Lowest-numbered matching code block wins.
  always_comb begin
    code_idx = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (code_hit[i]) code_idx = IDXW'(i);
    end
  end

  always_comb begin
    if (data_en && preg_hit)           tgt = TGT_PREG;
    else if (data_en && io_hit)        tgt = TGT_IO;
    else if (data_en && ram_hit)       tgt = TGT_RAM;
    else if (code_en && (|code_hit))   tgt = TGT_CODE;
    else                               tgt = TGT_NONE;
  end

  always_comb begin
    code_cs = '0;
    if (tgt == TGT_CODE) code_cs[code_idx] = 1'b1;
    code_oe = code_cs;
    io_cs   = (tgt == TGT_IO);
    io_oe   = io_cs && data_rd;
    ram_cs  = (tgt == TGT_RAM);
    ram_oe  = ram_cs && data_rd;
    preg_rd = (tgt == TGT_PREG) && data_rd;
  end
endmodule

// File: rtl/pgmap_decoder.sv
module pgmap_decoder
  import pgmap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W,
  parameter int DW = DATA_W,
  parameter int NC = N_CODE,
  parameter int CW = CODE_W,
  parameter int RW = RAM_W,
  parameter int IW = IO_W,
  localparam int CBW = AW - CW,
  localparam int RBW = AW - RW,
  localparam int IBW = AW - IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NC*CBW-1:0] cfg_code_base,
  input  logic [NC*PW-1:0]  cfg_code_page,
  input  logic [NC-1:0]     cfg_code_anypage,
  input  logic [RBW-1:0]    cfg_ram_base,
  input  logic [IBW-1:0]    cfg_io_base,
  input  logic [AW-1:0]     cfg_page_addr,
  input  logic              cfg_combined,
  input  logic [AW-1:0]     addr,
  input  logic              psen_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdata_vld,
  output logic [NC-1:0]     code_cs_n,
  output logic [NC-1:0]     code_oe_n,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              io_cs_n,
  output logic              io_oe_n
);
  logic [NC*CBW-1:0] code_base_q;
  logic [NC*PW-1:0]  code_page_q;
  logic [NC-1:0]     code_anypage_q;
  logic [RBW-1:0]    ram_base_q;
  logic [IBW-1:0]    io_base_q;
  logic [AW-1:0]     cfg_page_addr_q;
  logic              cfg_combined_q;
  logic [PW-1:0]     page_q;
  logic [NC-1:0]     code_hit;
  logic              ram_hit;
  logic              io_hit;
  logic              preg_hit;
  logic [NC-1:0]     code_cs;
  logic [NC-1:0]     code_oe;
  logic              ram_cs;
  logic              ram_oe;
  logic              io_cs;
  logic              io_oe;
  logic              preg_rd;

  pgmap_cfg_regs #(
    .AW(AW), .PW(PW), .NC(NC), .CBW(CBW), .RBW(RBW), .IBW(IBW)
  ) u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .code_base_i    (cfg_code_base),
    .code_page_i    (cfg_code_page),
    .code_anypage_i (cfg_code_anypage),
    .ram_base_i     (cfg_ram_base),
    .io_base_i      (cfg_io_base),
    .page_addr_i    (cfg_page_addr),
    .combined_i     (cfg_combined),
    .code_base_q    (code_base_q),
    .code_page_q    (code_page_q),
    .code_anypage_q (code_anypage_q),
    .ram_base_q     (ram_base_q),
    .io_base_q      (io_base_q),
    .page_addr_q    (cfg_page_addr_q),
    .combined_q     (cfg_combined_q)
  );

  pgmap_page_reg #(.AW(AW), .PW(PW), .DW(DW)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_n      (wr_n),
    .wdata     (wdata),
    .page_addr (cfg_page_addr_q),
    .page_q    (page_q)
  );

  pgmap_region_match #(
    .AW(AW), .PW(PW), .NC(NC), .CW(CW), .RW(RW), .IW(IW)
  ) u_match (
    .addr         (addr),
    .page         (page_q),
    .code_base    (code_base_q),
    .code_page    (code_page_q),
    .code_anypage (code_anypage_q),
    .ram_base     (ram_base_q),
    .io_base      (io_base_q),
    .page_addr    (cfg_page_addr_q),
    .code_hit     (code_hit),
    .ram_hit      (ram_hit),
    .io_hit       (io_hit),
    .preg_hit     (preg_hit)
  );

  pgmap_arbiter #(.NC(NC)) u_arb (
    .code_hit (code_hit),
    .ram_hit  (ram_hit),
    .io_hit   (io_hit),
    .preg_hit (preg_hit),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .combined (cfg_combined_q),
    .code_cs  (code_cs),
    .code_oe  (code_oe),
    .ram_cs   (ram_cs),
    .ram_oe   (ram_oe),
    .io_cs    (io_cs),
    .io_oe    (io_oe),
    .preg_rd  (preg_rd)
  );

  assign code_cs_n = ~code_cs;
  assign code_oe_n = ~code_oe;
  assign ram_cs_n  = ~ram_cs;
  assign ram_oe_n  = ~ram_oe;
  assign io_cs_n   = ~io_cs;
  assign io_oe_n   = ~io_oe;
  assign rdata_vld = preg_rd;
  assign rdata     = preg_rd ? {{(DW-PW){1'b0}}, page_q} : '0;
endmodule

// File: rtl/pgmap_decoder_chk.sv
module pgmap_decoder_chk #(
  parameter int AW = 16,
  parameter int PW = 4,
  parameter int DW = 8,
  parameter int NC = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] wdata,
  input logic [AW-1:0] page_addr,
  input logic          combined,
  input logic [PW-1:0] page_q,
  input logic [NC-1:0] code_cs_n,
  input logic [NC-1:0] code_oe_n,
  input logic          ram_cs_n,
  input logic          ram_oe_n,
  input logic          io_cs_n,
  input logic          io_oe_n,
  input logic          rdata_vld
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~code_cs_n, ~ram_cs_n, ~io_cs_n, rdata_vld}) <= 1); // R5

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (&(code_oe_n | ~code_cs_n)) && (ram_oe_n || !ram_cs_n) && (io_oe_n || !io_cs_n)); // R6

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && rd_n && wr_n) |-> ((&code_cs_n) && (&code_oe_n) && ram_cs_n && ram_oe_n
                                  && io_cs_n && io_oe_n && !rdata_vld)); // R1

  AST_SEP_PSEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!combined && !psen_n && rd_n && wr_n) |-> (ram_cs_n && io_cs_n && !rdata_vld)); // R7

  AST_SEP_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!combined && psen_n && !rd_n) |-> (&code_cs_n)); // R7

  AST_WRITE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (psen_n && rd_n && !wr_n) |-> ((&code_cs_n) && ram_oe_n && io_oe_n && !rdata_vld)); // R8

  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && addr == page_addr) |=> (page_q == $past(wdata[PW-1:0]))); // R2

  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && addr == page_addr) |=> $stable(page_q)); // R2

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(combined) && $stable(page_addr)); // R10
endmodule

bind pgmap_decoder pgmap_decoder_chk #(.AW(AW), .PW(PW), .DW(DW), .NC(NC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .psen_n    (psen_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .wdata     (wdata),
  .page_addr (cfg_page_addr_q),
  .combined  (cfg_combined_q),
  .page_q    (page_q),
  .code_cs_n (code_cs_n),
  .code_oe_n (code_oe_n),
  .ram_cs_n  (ram_cs_n),
  .ram_oe_n  (ram_oe_n),
  .io_cs_n   (io_cs_n),
  .io_oe_n   (io_oe_n),
  .rdata_vld (rdata_vld)
);

// File: tb/pgmap_decoder_tb.sv
module pgmap_decoder_tb;
  localparam int PG_ADDR = 'hC4F0;
  localparam int IO_BASE = 'hC4;
  localparam int RAM_BASE = 'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_code_base;
  logic [31:0] cfg_code_page;
  logic [7:0]  cfg_code_anypage;
  logic [4:0]  cfg_ram_base;
  logic [7:0]  cfg_io_base;
  logic [15:0] cfg_page_addr;
  logic        cfg_combined;
  logic [15:0] addr = '0;
  logic        psen_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_vld;
  logic [7:0]  code_cs_n;
  logic [7:0]  code_oe_n;
  logic        ram_cs_n;
  logic        ram_oe_n;
  logic        io_cs_n;
  logic        io_oe_n;

  int checks = 0;
  int fails = 0;

  // Model state (configuration as latched at reset)
  int m_slot[8]  = '{0, 1, 2, 3, 1, 2, 0, 3};
  int m_pg[8]    = '{0, 0, 0, 0, 1, 1, 5, 0};
  bit m_any[8]   = '{0, 0, 0, 0, 0, 0, 0, 1};
  int m_ram_lo   = RAM_BASE * 2048;
  int m_io_lo    = IO_BASE * 256;
  bit m_comb;
  int m_page;

  always #4 clk = ~clk;

  pgmap_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_code_base(cfg_code_base), .cfg_code_page(cfg_code_page),
    .cfg_code_anypage(cfg_code_anypage), .cfg_ram_base(cfg_ram_base),
    .cfg_io_base(cfg_io_base), .cfg_page_addr(cfg_page_addr),
    .cfg_combined(cfg_combined),
    .addr(addr), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
    .rdata(rdata), .rdata_vld(rdata_vld),
    .code_cs_n(code_cs_n), .code_oe_n(code_oe_n),
    .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
    .io_cs_n(io_cs_n), .io_oe_n(io_oe_n)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
    $finish;
  end

  // Behavioural reference: strobes active high here.
  task automatic model(input int a, input bit ps, input bit rd, input bit wr,
                       output logic [28:0] e, output string kind);
    bit cen, drd, den, found;
    logic [7:0] ccs, rdv;
    bit rcs, roe, ics, ioe, rv;
    cen = m_comb ? (ps || rd) : ps;
    drd = m_comb ? (ps || rd) : rd;
    den = drd || wr;
    ccs = '0; rdv = '0; rcs = 0; roe = 0; ics = 0; ioe = 0; rv = 0; found = 0;
    kind = "none";
    if (den && a == PG_ADDR) begin
      rv = drd; rdv = drd ? 8'(m_page) : 8'h00; kind = "preg";
    end else if (den && a >= m_io_lo && a < m_io_lo + 256) begin
      ics = 1; ioe = drd; kind = "io";
    end else if (den && a >= m_ram_lo && a < m_ram_lo + 2048) begin
      rcs = 1; roe = drd; kind = "ram";
    end else if (cen) begin
      for (int i = 0; i < 8; i++) begin
        if (!found && a >= m_slot[i] * 16384 && a < (m_slot[i] + 1) * 16384
            && (m_any[i] || m_pg[i] == m_page)) begin
          ccs[i] = 1'b1; found = 1; kind = "code";
        end
      end
    end
    e = {~ccs, ~ccs, ~rcs, ~roe, ~ics, ~ioe, rv, rdv};
  endtask

  task automatic probe(input int a, input bit ps, input bit rd, input bit wr,
                       input int wd, input string tag);
    logic [28:0] exp_v, got_v;
    string kind;
    @(negedge clk);
    addr = 16'(a); psen_n = !ps; rd_n = !rd; wr_n = !wr; wdata = 8'(wd);
    model(a, ps, rd, wr, exp_v, kind);
    #3;
    got_v = {code_cs_n, code_oe_n, ram_cs_n, ram_oe_n, io_cs_n, io_oe_n, rdata_vld, rdata};
    checks++;
    if (got_v !== exp_v) begin
      fails++;
      $display("FAIL %s addr=%h ps=%0b rd=%0b wr=%0b page=%0d: got %h expected %h",
               tag, a, ps, rd, wr, m_page, got_v, exp_v);
    end
    if (wr && a == PG_ADDR) m_page = wd & 15;
  endtask

  task automatic drive_cfg(input bit comb);
    for (int i = 0; i < 8; i++) begin
      cfg_code_base[2*i +: 2]  = 2'(m_slot[i]);
      cfg_code_page[4*i +: 4]  = 4'(m_pg[i]);
      cfg_code_anypage[i]      = m_any[i];
    end
    cfg_ram_base  = 5'(RAM_BASE);
    cfg_io_base   = 8'(IO_BASE);
    cfg_page_addr = 16'(PG_ADDR);
    cfg_combined  = comb;
    m_comb = comb;
  endtask

  task automatic do_reset(input bit comb);
    @(negedge clk);
    rst_n = 1'b0;
    psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    drive_cfg(comb);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_page = 0;
  endtask

  task automatic directed();
    // R1: reset state
    probe(16'h0000, 0, 0, 0, 0, "R1");
    probe(PG_ADDR, 0, 1, 0, 0, "R1");
    // R2: page write, upper data bits ignored, read back
    probe(PG_ADDR, 0, 0, 1, 'hF3, "R2");
    probe(PG_ADDR, 0, 1, 0, 0, "R2");
    probe(PG_ADDR, 0, 0, 1, 0, "R2");
    probe(PG_ADDR, 0, 1, 0, 0, "R2");
    // R3: page-specific and any-page code blocks
    probe(16'h4000, 1, 0, 0, 0, "R3");
    probe(PG_ADDR, 0, 0, 1, 1, "R3");
    probe(16'h4000, 1, 0, 0, 0, "R3");
    probe(16'h8123, 1, 0, 0, 0, "R3");
    probe(PG_ADDR, 0, 0, 1, 5, "R3");
    probe(16'h0000, 1, 0, 0, 0, "R3");
    probe(PG_ADDR, 0, 0, 1, 9, "R3");
    probe(16'hC000, 1, 0, 0, 0, "R3");
    probe(16'h8000, 1, 0, 0, 0, "R9");
    probe(PG_ADDR, 0, 0, 1, 0, "R2");
    // R4: window edges
    probe(16'hA000, 0, 1, 0, 0, "R4");
    probe(16'hA7FF, 0, 1, 0, 0, "R4");
    probe(16'hA800, 0, 1, 0, 0, "R4");
    probe(16'h9FFF, 0, 1, 0, 0, "R4");
    probe(16'hC400, 0, 1, 0, 0, "R4");
    probe(16'hC4FF, 0, 1, 0, 0, "R4");
    probe(16'hC500, 0, 1, 0, 0, "R4");
    // R5: priority over code blocks and over I/O
    probe(16'hA010, 1, 0, 0, 0, "R5");
    probe(16'hC410, 1, 0, 0, 0, "R5");
    probe(PG_ADDR, 1, 0, 0, 0, "R5");
    // R8: writes
    probe(16'hA020, 0, 0, 1, 0, "R8");
    probe(16'h1000, 0, 0, 1, 0, "R8");
  endtask

  function automatic string pick_tag(input string kind, input bit ps, input bit rd, input bit wr);
    if (!ps && !rd && !wr) return "R1";
    if (kind == "none") return "R9";
    if (kind == "preg") return "R5";
    if (!ps && !rd) return "R8";
    return m_comb ? "R6" : "R7";
  endfunction

  task automatic sweep();
    bit ps, rd, wr;
    int a, lo;
    logic [28:0] dummy;
    string kind;
    for (int pg = 0; pg < 16; pg++) begin
      probe(PG_ADDR, 0, 0, 1, pg, "R2");
      for (int hi = 0; hi < 256; hi++) begin
        lo = (hi * 37 + pg * 11) & 255;
        if (hi == IO_BASE && pg[0]) lo = PG_ADDR & 255;
        a = hi * 256 + lo;
        for (int s = 0; s < 5; s++) begin
          ps = (s == 0) || (s == 3);
          rd = (s == 1) || (s == 3);
          wr = (s == 2);
          model(a, ps, rd, wr, dummy, kind);
          probe(a, ps, rd, wr, pg, pick_tag(kind, ps, rd, wr));
        end
      end
    end
  endtask

  initial begin
    drive_cfg(1'b0);
    do_reset(1'b0);
    directed();
    sweep();
    do_reset(1'b1);
    directed();
    sweep();
    // R10: config pins move after release; decoding keeps the latched setup
    probe(PG_ADDR, 0, 0, 1, 0, "R10");
    @(negedge clk);
    cfg_ram_base = 5'h00;
    cfg_combined = 1'b0;
    cfg_code_anypage = 8'h00;
    cfg_page_addr = 16'h0000;
    probe(16'hA010, 1, 0, 0, 0, "R10");
    probe(16'h0010, 0, 1, 0, 0, "R10");
    probe(PG_ADDR, 0, 1, 0, 0, "R10");
    probe(PG_ADDR, 0, 0, 1, 9, "R10");
    probe(16'hC010, 1, 0, 0, 0, "R10");
    probe(16'h0000, 0, 0, 1, 3, "R10");
    probe(PG_ADDR, 0, 1, 0, 0, "R10");
    summary();
    $finish;
  end
endmodule